// File: doc/BRIEF.md
# Dual-Context Parallel Port DMA Channel

This block is a single DMA channel that streams bytes between system memory and a parallel-port device, in either direction. Software describes each buffer with a 64-bit context word that holds a base address, a length and a "last" flag. There are two such contexts, A and B, which form a ping-pong pair. Software fills one, marks it valid and can prepare the other while the engine drains the first. When the engine finishes a context, it clears that context's valid flag and continues with the other context if that one is valid.

On the memory side the channel issues single-byte read or write requests and holds each one until the memory acknowledges it. On the device side it offers bytes through a valid/ready handshake for memory-to-device transfers, or accepts bytes through one for device-to-memory transfers. A context whose last flag is set ends with a one-cycle terminal-count pulse to the device. Software sees a control/status register, the two context registers and a read-only diagnostic word. The diagnostic word exposes the context in use, the busy state and the remaining byte count.

Top module: `ppdma_chan`

## Requirements
- R1: After `rst_n` is released, the control/status word (address 0) and the diagnostic word (address 3) read as zero. Context A is at address 1 and context B at address 2. Writes to address 3 are ignored.
- R2: A context word keeps the base address in bits 31:0, the byte count minus one in bits 43:32 and the last flag in bit 63. All other bits read back as zero.
- R3: With direction bit 0 of the control word clear, the engine reads memory bytes in ascending order from the base address, at any byte alignment, and presents them in the same order on `dev_out_data`.
- R4: With direction bit 0 set, the engine takes bytes from the device and writes them in ascending order, starting at the base address with its low 6 bits forced to zero.
- R5: If a byte would fall past the end of the 4096-byte page that holds the (aligned) base address, the transfer stops after the page's last byte and the context counts as complete.
- R6: When a context completes and its last flag is 1, `dev_tc` is high for exactly one cycle after the final byte. When the flag is 0, no pulse is produced.
- R7: Bit 4 of the control word is the valid flag of context A and bit 3 is the valid flag of context B. After reset, context A is served first. A completed context has its valid flag cleared, and the engine moves to the other context if that one is valid.
- R8: While enable bit 1 is clear, no memory request, device handshake or terminal-count pulse is issued, and the remaining count is held. Setting the bit again resumes the transfer with no byte lost or repeated.
- R9: While reset bit 2 is set, both valid flags are held at zero, the engine is idle with context A selected, its remaining count is zero and no transfer takes place.
- R10: Diagnostic bit 0 gives the context in use (0 = A, 1 = B). Bit 1 is 1 while the channel is enabled and working on a context. Bits 13:2 hold the remaining count, which is loaded from the length field and decremented by one per byte moved, except on the final byte.
- R11: Once raised, a memory request keeps its address stable until it is acknowledged, unless the channel is frozen or reset in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 context A, 2 context B, 3 diagnostic |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the register selected by `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte for the device |
| dev_out_ready | input | 1 | Device accepts the offered byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Channel accepts the device byte |
| dev_tc | output | 1 | Terminal-count pulse to the device |

## Verification
The main transfer path is driven from a vector table that mixes both directions with different base alignments and lengths: a one-byte context, a 16-byte context with an odd base, buffers that run into the page end, and a full 4096-byte request that starts mid-page. Together these separate a correct byte order and count from off-by-one lengths, a missing alignment mask on device-to-memory transfers, and truncation that stops one byte early or late. Each vector also checks whether a terminal-count pulse appears, which shows that the last flag is honoured per context. Directed tests then freeze a transfer mid-buffer, reset the channel mid-buffer, and chain A into B with B still pending, to check that progress is kept, that state is cleared, and that the ping-pong order and the context-in-use bit are right.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

    localparam int REG_W = 64;

    // control word bit positions
    localparam int CTL_DIR_BIT    = 0;
    localparam int CTL_EN_BIT     = 1;
    localparam int CTL_RST_BIT    = 2;
    localparam int CTL_VALB_BIT   = 3;
    localparam int CTL_VALA_BIT   = 4;

    // context word layout
    localparam int CTX_LEN_LSB    = 32;
    localparam int CTX_LAST_BIT   = 63;

    // diagnostic word layout
    localparam int DIAG_SEL_BIT   = 0;
    localparam int DIAG_BUSY_BIT  = 1;
    localparam int DIAG_CNT_LSB   = 2;

    // register addresses
    localparam logic [1:0] ADR_CTL  = 2'd0;
    localparam logic [1:0] ADR_CTXA = 2'd1;
    localparam logic [1:0] ADR_CTXB = 2'd2;
    localparam logic [1:0] ADR_DIAG = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DEV  = 2'd2,
        ST_TC   = 2'd3
    } eng_state_e;

endpackage

// File: rtl/ppdma_regs.sv
module ppdma_regs
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [REG_W-1:0]       diag_word,
    input  logic [1:0]             clr_valid,
    output logic                   ctl_dir,
    output logic                   ctl_en,
    output logic                   ctl_rst,
    output logic [1:0]             ctx_valid,
    output logic [1:0][REG_W-1:0]  ctx_words
);

    localparam logic [REG_W-1:0] BASE_MASK = (REG_W'(1) << ADDR_W) - REG_W'(1);
    localparam logic [REG_W-1:0] LEN_MASK  = ((REG_W'(1) << LEN_W) - REG_W'(1)) << CTX_LEN_LSB;
    localparam logic [REG_W-1:0] LAST_MASK = REG_W'(1) << CTX_LAST_BIT;
    localparam logic [REG_W-1:0] CTX_MASK  = BASE_MASK | LEN_MASK | LAST_MASK;

    typedef struct packed {
        logic                   dir;
        logic                   en;
        logic                   rst;
        logic [1:0]             valid;   // [0] = A, [1] = B
        logic [1:0][REG_W-1:0]  ctx;     // [0] = A, [1] = B
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_we) begin
            unique case (reg_addr)
                ADR_CTL: begin
                    d.dir      = reg_wdata[CTL_DIR_BIT];
                    d.en       = reg_wdata[CTL_EN_BIT];
                    d.rst      = reg_wdata[CTL_RST_BIT];
                    d.valid[0] = reg_wdata[CTL_VALA_BIT];
                    d.valid[1] = reg_wdata[CTL_VALB_BIT];
                end
                ADR_CTXA: d.ctx[0] = reg_wdata & CTX_MASK;
                ADR_CTXB: d.ctx[1] = reg_wdata & CTX_MASK;
                default: ;
            endcase
        end
        // completion clears win over a simultaneous software write
        d.valid = d.valid & ~clr_valid;
        if (q.rst) begin
            d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTL: begin
                reg_rdata[CTL_DIR_BIT]  = q.dir;
                reg_rdata[CTL_EN_BIT]   = q.en;
                reg_rdata[CTL_RST_BIT]  = q.rst;
                reg_rdata[CTL_VALA_BIT] = q.valid[0];
                reg_rdata[CTL_VALB_BIT] = q.valid[1];
            end
            ADR_CTXA: reg_rdata = q.ctx[0];
            ADR_CTXB: reg_rdata = q.ctx[1];
            default:  reg_rdata = diag_word;
        endcase
    end

    assign ctl_dir   = q.dir;
    assign ctl_en    = q.en;
    assign ctl_rst   = q.rst;
    assign ctx_valid = q.valid;
    assign ctx_words = q.ctx;

endmodule

// File: rtl/ppdma_ctx_unpack.sv
module ppdma_ctx_unpack
    import ppdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 12,
    parameter int ALIGN_W = 6
) (
    input  logic [REG_W-1:0]   word,
    input  logic               to_mem,
    output logic [ADDR_W-1:0]  base,
    output logic [LEN_W-1:0]   len,
    output logic               last
);

    logic [ADDR_W-1:0] raw_base;
    logic              unused_bits;

    assign raw_base    = word[ADDR_W-1:0];
    assign len         = word[CTX_LEN_LSB +: LEN_W];
    assign last        = word[CTX_LAST_BIT];
    assign unused_bits = ^word;

    // device-to-memory buffers start on an aligned boundary
    assign base = to_mem ? {raw_base[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}} : raw_base;

endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
    import ppdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 12,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   en,
    input  logic                   dir,
    input  logic [1:0]             ctx_valid,
    input  logic [1:0][REG_W-1:0]  ctx_words,
    output logic [1:0]             clr_valid,
    output logic                   cur_sel,
    output logic                   busy,
    output logic [LEN_W-1:0]       remain,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic                   mem_ack,
    input  logic [7:0]             mem_rdata,
    output logic                   dev_out_valid,
    output logic [7:0]             dev_out_data,
    input  logic                   dev_out_ready,
    input  logic                   dev_in_valid,
    input  logic [7:0]             dev_in_data,
    output logic                   dev_in_ready,
    output logic                   dev_tc
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);

    typedef struct packed {
        eng_state_e         state;
        logic               cur;
        logic               dir;
        logic               last;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   cnt;
        logic [7:0]         data;
    } eng_t;

    eng_t q, d;

    logic [1:0][ADDR_W-1:0] un_base;
    logic [1:0][LEN_W-1:0]  un_len;
    logic [1:0]             un_last;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_ctx
            ppdma_ctx_unpack #(
                .ADDR_W  (ADDR_W),
                .LEN_W   (LEN_W),
                .ALIGN_W (ALIGN_W)
            ) u_unpack (
                .word   (ctx_words[g]),
                .to_mem (dir),
                .base   (un_base[g]),
                .len    (un_len[g]),
                .last   (un_last[g])
            );
        end
    endgenerate

    // choice of context when idle: current one first, then the other
    logic pick_hit;
    logic pick_sel;

    always_comb begin
        pick_hit = 1'b0;
        pick_sel = q.cur;
        if (ctx_valid[q.cur]) begin
            pick_hit = 1'b1;
        end else if (ctx_valid[~q.cur]) begin
            pick_hit = 1'b1;
            pick_sel = ~q.cur;
        end
    end

    logic byte_done;
    logic page_end;

    assign page_end = &q.addr[PAGE_W-1:0];

    always_comb begin
        d             = q;
        byte_done     = 1'b0;
        clr_valid     = '0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        dev_out_valid = 1'b0;
        dev_in_ready  = 1'b0;
        dev_tc        = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (en && pick_hit) begin
                    d.cur   = pick_sel;
                    d.dir   = dir;
                    d.addr  = un_base[pick_sel];
                    d.cnt   = un_len[pick_sel];
                    d.last  = un_last[pick_sel];
                    d.state = dir ? ST_DEV : ST_MEM;
                end
            end
            ST_MEM: begin
                mem_req = en;
                mem_we  = q.dir;
                if (en && mem_ack) begin
                    if (q.dir) begin
                        byte_done = 1'b1;
                    end else begin
                        d.data  = mem_rdata;
                        d.state = ST_DEV;
                    end
                end
            end
            ST_DEV: begin
                if (!q.dir) begin
                    dev_out_valid = en;
                    if (en && dev_out_ready) begin
                        byte_done = 1'b1;
                    end
                end else begin
                    dev_in_ready = en;
                    if (en && dev_in_valid) begin
                        d.data  = dev_in_data;
                        d.state = ST_MEM;
                    end
                end
            end
            ST_TC: begin
                if (en) begin
                    dev_tc  = 1'b1;
                    d.cur   = ~q.cur;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (byte_done) begin
            if ((q.cnt == '0) || page_end) begin
                clr_valid[q.cur] = 1'b1;
                if (q.last) begin
                    d.state = ST_TC;
                end else begin
                    d.cur   = ~q.cur;
                    d.state = ST_IDLE;
                end
            end else begin
                d.addr  = q.addr + ADDR_ONE;
                d.cnt   = q.cnt - LEN_ONE;
                d.state = q.dir ? ST_DEV : ST_MEM;
            end
        end

        if (soft_rst) begin
            d         = '0;
            d.state   = ST_IDLE;
            clr_valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cur_sel      = q.cur;
    assign busy         = (q.state != ST_IDLE);
    assign remain       = q.cnt;
    assign mem_addr     = q.addr;
    assign mem_wdata    = q.data;
    assign dev_out_data = q.data;

endmodule

// File: rtl/ppdma_chan.sv
module ppdma_chan
    import ppdma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 12,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic               mem_ack,
    input  logic [7:0]         mem_rdata,
    output logic               dev_out_valid,
    output logic [7:0]         dev_out_data,
    input  logic               dev_out_ready,
    input  logic               dev_in_valid,
    input  logic [7:0]         dev_in_data,
    output logic               dev_in_ready,
    output logic               dev_tc
);

    logic                   ctl_dir;
    logic                   ctl_en;
    logic                   ctl_rst;
    logic [1:0]             ctx_valid;
    logic [1:0][REG_W-1:0]  ctx_words;
    logic [1:0]             clr_valid;
    logic                   cur_sel;
    logic                   eng_busy;
    logic [LEN_W-1:0]       remain;
    logic [REG_W-1:0]       diag_word;

    always_comb begin
        diag_word                          = '0;
        diag_word[DIAG_SEL_BIT]            = cur_sel;
        diag_word[DIAG_BUSY_BIT]           = ctl_en && eng_busy;
        diag_word[DIAG_CNT_LSB +: LEN_W]   = remain;
    end

    ppdma_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .diag_word  (diag_word),
        .clr_valid  (clr_valid),
        .ctl_dir    (ctl_dir),
        .ctl_en     (ctl_en),
        .ctl_rst    (ctl_rst),
        .ctx_valid  (ctx_valid),
        .ctx_words  (ctx_words)
    );

    ppdma_engine #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .PAGE_W  (PAGE_W),
        .ALIGN_W (ALIGN_W)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (ctl_rst),
        .en            (ctl_en),
        .dir           (ctl_dir),
        .ctx_valid     (ctx_valid),
        .ctx_words     (ctx_words),
        .clr_valid     (clr_valid),
        .cur_sel       (cur_sel),
        .busy          (eng_busy),
        .remain        (remain),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_ready (dev_out_ready),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_in_ready  (dev_in_ready),
        .dev_tc        (dev_tc)
    );

endmodule

// File: rtl/ppdma_chan_chk.sv
module ppdma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_en,
    input logic               ctl_rst,
    input logic [1:0]         ctx_valid,
    input logic               eng_busy,
    input logic               cur_sel,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               dev_out_valid,
    input logic               dev_in_ready,
    input logic               dev_tc
);

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (!mem_req && !dev_out_valid && !dev_in_ready && !dev_tc)); // R8

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |=> !dev_tc); // R6

    AST_TC_IN_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |-> eng_busy); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (!ctl_en || ctl_rst || (mem_req && $stable(mem_addr)))); // R11

    AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> (ctx_valid == 2'b00 && !eng_busy && !cur_sel)); // R9

endmodule

bind ppdma_chan ppdma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_en        (ctl_en),
    .ctl_rst       (ctl_rst),
    .ctx_valid     (ctx_valid),
    .eng_busy      (eng_busy),
    .cur_sel       (cur_sel),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .dev_out_valid (dev_out_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_tc        (dev_tc)
);

// File: tb/ppdma_chan_tb.sv
`timescale 1ns/1ps
module ppdma_chan_tb_top;

    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        dev_out_valid;
    logic [7:0]  dev_out_data;
    logic        dev_out_ready = 1'b1;
    logic        dev_in_valid = 1'b1;
    logic [7:0]  dev_in_data;
    logic        dev_in_ready;
    logic        dev_tc;

    always #(PERIOD/2) clk = ~clk;

    ppdma_chan dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_tc(dev_tc)
    );

    function automatic logic [7:0] memf(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // environment models and logs
    logic [7:0]  out_log [0:8191];
    logic [31:0] wr_addr [0:255];
    logic [7:0]  wr_data [0:255];
    int          out_n = 0;
    int          wr_n = 0;
    int          tc_n = 0;
    int          hold_err = 0;
    logic [7:0]  in_ctr = 8'h30;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;

    assign dev_in_data = in_ctr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            prev_pend <= 1'b0;
        end else begin
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= memf(mem_addr);
            end else begin
                mem_ack <= 1'b0;
            end
            if (mem_req && mem_ack && mem_we && wr_n < 256) begin
                wr_addr[wr_n] <= mem_addr;
                wr_data[wr_n] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
            if (prev_pend && mem_req && mem_addr != prev_addr) hold_err <= hold_err + 1;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
            if (dev_out_valid && dev_out_ready && out_n < 8192) begin
                out_log[out_n] <= dev_out_data;
                out_n <= out_n + 1;
            end
            if (dev_in_valid && dev_in_ready) in_ctr <= in_ctr + 8'd1;
            if (dev_tc) tc_n <= tc_n + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [63:0] c, g;
        bit done = 1'b0;
        for (int i = 0; i < 20000 && !done; i++) begin
            reg_rd(2'd0, c);
            reg_addr = 2'd3;
            #1;
            g = reg_rdata;
            if (c[4:3] == 2'b00 && !g[1]) done = 1'b1;
        end
        check(done, {req, " completion"}, done, 1);
    endtask

    task automatic wait_out(input int target);
        for (int i = 0; i < 20000 && out_n < target; i++) @(negedge clk);
    endtask

    // vector: bit 63 last, bit 62 direction (bench only), 43:32 len-1, 31:0 base
    localparam int NVEC = 6;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_0000_0000_0100,
        64'h8000_000F_0000_0233,
        64'h8000_0009_0000_0FFC,
        64'h4000_0003_0000_1234,
        64'hC000_007F_0000_2FC0,
        64'h0000_0FFF_ABCD_E7FF
    };

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv, cv, dv;
        int os, ws, ts, snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and map
        reg_rd(2'd0, rv);
        check(rv == 64'h0, "R1 control after reset", rv, 0);
        reg_rd(2'd3, rv);
        check(rv == 64'h0, "R1 diag after reset", rv, 0);
        reg_wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(2'd3, rv);
        check(rv == 64'h0, "R1 diag write ignored", rv, 0);

        // R2: context layout, unused bits zero
        reg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(2'd2, rv);
        check(rv == 64'h8000_0FFF_FFFF_FFFF, "R2 context B readback", rv, 64'h8000_0FFF_FFFF_FFFF);
        reg_wr(2'd1, 64'h8000_0ABC_1234_5678);
        reg_rd(2'd1, rv);
        check(rv == 64'h8000_0ABC_1234_5678, "R2 context A readback", rv, 64'h8000_0ABC_1234_5678);

        // main table: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            logic        vdir, vlast;
            logic [11:0] vlen;
            logic [31:0] vbase, eff;
            int          n, off, in_s;
            bit          ok;
            vdir  = VEC[i][62];
            vlast = VEC[i][63];
            vlen  = VEC[i][43:32];
            vbase = VEC[i][31:0];
            eff   = vdir ? {vbase[31:6], 6'b0} : vbase;
            off   = int'(eff[11:0]);
            n     = int'(vlen) + 1;
            if (n > 4096 - off) n = 4096 - off;
            os = out_n; ws = wr_n; ts = tc_n; in_s = int'(in_ctr);
            reg_wr(2'd1, VEC[i] & ~(64'h1 << 62));
            reg_wr(2'd0, 64'h12 | {63'b0, vdir});
            wait_done("R7 table");
            ok = 1'b1;
            if (!vdir) begin
                check(out_n - os == n, "R3/R5 bytes to device", out_n - os, n);
                for (int k = 0; k < n && k < out_n - os; k++)
                    if (out_log[os + k] != memf(eff + 32'(k))) ok = 1'b0;
                check(ok, "R3 byte order and data", ok, 1);
            end else begin
                check(wr_n - ws == n, "R4/R5 bytes to memory", wr_n - ws, n);
                for (int k = 0; k < n && k < wr_n - ws; k++) begin
                    if (wr_addr[ws + k] != eff + 32'(k)) ok = 1'b0;
                    if (wr_data[ws + k] != 8'(in_s + k)) ok = 1'b0;
                end
                check(ok, "R4 aligned addresses and data", ok, 1);
            end
            check(tc_n - ts == int'(vlast), "R6 terminal count per last flag", tc_n - ts, vlast);
            reg_rd(2'd3, dv);
            check(int'(dv[13:2]) == int'(vlen) - (n - 1), "R10 remaining count at end",
                  dv[13:2], int'(vlen) - (n - 1));
        end

        // R8: freeze mid-transfer
        os = out_n; ts = tc_n;
        reg_wr(2'd1, 64'h8000_0063_0000_0400);
        reg_wr(2'd0, 64'h12);
        wait_out(os + 10);
        reg_wr(2'd0, 64'h10);
        repeat (2) @(negedge clk);
        snap = out_n;
        reg_rd(2'd3, dv);
        check(int'(dv[13:2]) == 99 - (snap - os), "R10 count while frozen", dv[13:2], 99 - (snap - os));
        check(dv[1] == 1'b0, "R8 busy bit low when frozen", dv[1], 0);
        repeat (50) @(negedge clk);
        check(out_n == snap, "R8 no bytes while frozen", out_n, snap);
        reg_rd(2'd3, cv);
        check(cv == dv, "R8 state held while frozen", cv, dv);
        reg_wr(2'd0, 64'h12);
        wait_done("R8 resume");
        check(out_n - os == 100, "R8 all bytes after resume", out_n - os, 100);
        check(tc_n - ts == 1, "R8 R6 pulse after resume", tc_n - ts, 1);

        // R9: soft reset mid-transfer
        os = out_n;
        reg_wr(2'd1, 64'h0000_00C8_0000_0000);
        reg_wr(2'd0, 64'h12);
        wait_out(os + 5);
        reg_wr(2'd0, 64'h06);
        repeat (2) @(negedge clk);
        reg_rd(2'd3, dv);
        check(dv == 64'h0, "R9 diag cleared in reset", dv, 0);
        reg_rd(2'd0, cv);
        check(cv[4:3] == 2'b00, "R9 valid flags cleared", cv[4:3], 0);
        snap = out_n;
        repeat (20) @(negedge clk);
        check(out_n == snap, "R9 no transfer while reset", out_n, snap);
        reg_wr(2'd0, 64'h02);
        repeat (20) @(negedge clk);
        check(out_n == snap, "R9 nothing resumes after reset", out_n, snap);

        // R7: ping-pong A then B
        os = out_n; ts = tc_n;
        dev_out_ready = 1'b1;
        reg_wr(2'd1, 64'h0000_0003_0000_0300);
        reg_wr(2'd2, 64'h8000_0001_0000_0500);
        reg_wr(2'd0, 64'h1A);
        wait_out(os + 4);
        dev_out_ready = 1'b0;
        repeat (10) @(negedge clk);
        reg_rd(2'd3, dv);
        check(dv[0] == 1'b1, "R10 in-use bit shows B", dv[0], 1);
        check(dv[1] == 1'b1, "R10 busy bit during B", dv[1], 1);
        reg_rd(2'd0, cv);
        check(cv[4:3] == 2'b01, "R7 A cleared B still valid", cv[4:3], 2'b01);
        dev_out_ready = 1'b1;
        wait_done("R7 ping-pong");
        begin
            bit ok;
            ok = (out_n - os == 6);
            for (int k = 0; k < 4 && ok; k++) if (out_log[os + k] != memf(32'h300 + 32'(k))) ok = 1'b0;
            for (int k = 0; k < 2 && ok; k++) if (out_log[os + 4 + k] != memf(32'h500 + 32'(k))) ok = 1'b0;
            check(ok, "R7 A bytes then B bytes", out_n - os, 6);
        end
        check(tc_n - ts == 1, "R6 pulse only for B", tc_n - ts, 1);

        // R11: request address stability observed by memory model
        check(hold_err == 0, "R11 request address held", hold_err, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule